// File: doc/BRIEF.md
# Wait-Mode Clock and Wakeup Controller

This block parks a small CPU in a low-power wait state and wakes it again. When the core executes its wait instruction it raises `wait_exec` for one cycle. The controller then drops the CPU clock enable, keeps the peripheral clock enable high, and gives a one-cycle pulse that tells the core to clear its interrupt mask bit. While the CPU sleeps, peripherals keep running and can wake it.

Three events end the wait: an interrupt request whose enable is set, a debug break, or reset. An interrupt wake restarts the CPU clock and gives a one-cycle stack-start pulse in the cycle after the interrupt was seen. A break wake restarts the clock without that pulse and records the cause in a sticky status bit that software can read and clear. The watchdog enable output follows the inverse of a configuration disable bit, in wait as well as in run.

The state machine has four states. RUN is normal execution. ENTER is the first sleeping cycle, where the mask-clear pulse is given. WAIT is the steady sleeping state. STACK is the single wake cycle before an interrupt handler starts. The transitions are:
- sleep: RUN to ENTER on `wait_exec`.
- settle: ENTER to WAIT when no wake event is present.
- irq_wake: ENTER or WAIT to STACK on an enabled interrupt.
- brk_wake: ENTER or WAIT to RUN on a break.
- resume: STACK to RUN.
- reset: any state to RUN on reset.

Top module: `wait_ctl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released: `cpu_clk_en`=1, `per_clk_en`=1, `imask_clr`=0, `stack_go`=0 and `stat_rdata`=0.
- R2: `wait_exec` high in RUN causes `cpu_clk_en`=0 and `imask_clr`=1 in the next cycle. `imask_clr` is high for exactly that one cycle.
- R3: While the CPU sleeps, `per_clk_en` stays 1 and `cpu_clk_en` stays 0 until a wake event occurs.
- R4: An interrupt request with `irq_en`=0, or `irq_en`=1 without a request, leaves the CPU asleep.
- R5: `irq_req`=1 and `irq_en`=1 while asleep give `stack_go`=1 and `cpu_clk_en`=1 in the next cycle. `stack_go` lasts exactly one cycle, after which the CPU runs with `stack_go`=0.
- R6: `brk_req`=1 while asleep, including in the first sleeping cycle, returns the CPU to run in the next cycle with `stack_go`=0. A break takes priority over an interrupt that arrives in the same cycle.
- R7: A break that ends the sleep sets `stat_rdata` (break-wake flag) to 1 in the next cycle. The flag stays set until it is cleared. A break while running does not set it.
- R8: Writing (`stat_wr`=1) with `stat_wdata`=0 clears the flag. Writing 1 leaves it unchanged.
- R9: `wdog_en` equals the inverse of `wdog_dis` in every state, including while asleep.
- R10: Asserting `rst_n` low while asleep returns the controller to run with `cpu_clk_en`=1 and clears the flag. Reset overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_exec | input | 1 | One-cycle strobe: wait instruction executed |
| irq_req | input | 1 | Peripheral interrupt request |
| irq_en | input | 1 | Interrupt enable for `irq_req` |
| brk_req | input | 1 | Debug break request |
| wdog_dis | input | 1 | Configuration bit: 1 disables the watchdog |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Status write data (break-wake flag) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdog_en | output | 1 | Watchdog enable |
| imask_clr | output | 1 | Pulse: clear CPU interrupt mask bit |
| stack_go | output | 1 | Pulse: begin interrupt stacking |
| stat_rdata | output | 1 | Status read data (break-wake flag) |

## Verification
The wake logic is driven with the request alone, the enable alone, and both together. This separates a design that gates wake with the enable from one that wakes on either signal. A break is applied in several ways: together with a valid interrupt, in the very first sleeping cycle, and while the CPU runs. These cases show the priority order, whether the first sleeping cycle is covered, and that the flag is set only by a break that ends a sleep. Writes of 1 and of 0 to the status bit, and a reset in the middle of a sleep with the flag set, separate the clear paths from the set path.

// File: rtl/wait_ctl_pkg.sv
package wait_ctl_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_WAIT  = 2'd2,
        ST_STACK = 2'd3
    } wstate_t;
endpackage

// File: rtl/wait_ctl_fsm.sv
module wait_ctl_fsm
    import wait_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wait_exec,
    input  logic    irq_req,
    input  logic    irq_en,
    input  logic    brk_req,
    output logic    cpu_clk_en,
    output logic    imask_clr,
    output logic    stack_go,
    output logic    brk_wake
);
    wstate_t state_q, state_d;
    logic    asleep;
    logic    irq_wake;

    assign asleep   = (state_q == ST_ENTER) || (state_q == ST_WAIT);
    assign irq_wake = irq_req && irq_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (wait_exec) state_d = ST_ENTER;
            ST_ENTER,
            ST_WAIT: begin
                if (brk_req)       state_d = ST_RUN;
                else if (irq_wake) state_d = ST_STACK;
                else               state_d = ST_WAIT;
            end
            ST_STACK: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // Moore outputs
    always_comb begin
        cpu_clk_en = 1'b1;
        imask_clr  = 1'b0;
        stack_go   = 1'b0;
        unique case (state_q)
            ST_RUN:   cpu_clk_en = 1'b1;
            ST_ENTER: begin cpu_clk_en = 1'b0; imask_clr = 1'b1; end
            ST_WAIT:  cpu_clk_en = 1'b0;
            ST_STACK: stack_go = 1'b1;
            default:  cpu_clk_en = 1'b1;
        endcase
    end

    assign brk_wake = asleep && brk_req;

    AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wait_exec) |=> (imask_clr && !cpu_clk_en)); // R2
    AST_MASK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        imask_clr |=> !imask_clr); // R2
    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !irq_wake && !brk_req) |=> !cpu_clk_en); // R4
    AST_IRQ_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && irq_wake && !brk_req) |=> (stack_go && cpu_clk_en)); // R5
    AST_STACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        stack_go |=> (!stack_go && cpu_clk_en)); // R5
    AST_BRK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        brk_wake |=> (cpu_clk_en && !stack_go)); // R6
endmodule

// File: rtl/wait_ctl_flag.sv
module wait_ctl_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o
);
    logic flag_q;

    // set wins over a same-cycle software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               flag_q <= 1'b0;
        else if (set_i)           flag_q <= 1'b1;
        else if (wr_i && !wdata_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_i && !wdata_i)) |=> flag_o); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && wr_i && !wdata_i) |=> !flag_o); // R8
endmodule

// File: rtl/wait_ctl.sv
module wait_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_exec,
    input  logic irq_req,
    input  logic irq_en,
    input  logic brk_req,
    input  logic wdog_dis,
    input  logic stat_wr,
    input  logic stat_wdata,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic wdog_en,
    output logic imask_clr,
    output logic stack_go,
    output logic stat_rdata
);
    logic brk_wake;

    wait_ctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_exec  (wait_exec),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .brk_req    (brk_req),
        .cpu_clk_en (cpu_clk_en),
        .imask_clr  (imask_clr),
        .stack_go   (stack_go),
        .brk_wake   (brk_wake)
    );

    wait_ctl_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (brk_wake),
        .wr_i    (stat_wr),
        .wdata_i (stat_wdata),
        .flag_o  (stat_rdata)
    );

    // peripherals keep their clock in every state; watchdog follows config (R3, R9)
    assign per_clk_en = 1'b1;
    assign wdog_en    = !wdog_dis;
endmodule

// File: tb/wait_ctl_tb.sv
module wait_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_exec = 1'b0, irq_req = 1'b0, irq_en = 1'b0, brk_req = 1'b0;
    logic wdog_dis = 1'b0, stat_wr = 1'b0, stat_wdata = 1'b0;
    logic cpu_clk_en, per_clk_en, wdog_en, imask_clr, stack_go, stat_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expected: {cpu, per, wdog, mask, stack, flag}
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wait_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wait_exec(wait_exec), .irq_req(irq_req),
        .irq_en(irq_en), .brk_req(brk_req), .wdog_dis(wdog_dis),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wdog_en(wdog_en),
        .imask_clr(imask_clr), .stack_go(stack_go), .stat_rdata(stat_rdata)
    );

    // driver: apply inputs at negedge, queue the outputs expected after the edge
    task automatic step(input logic rst, input logic we, input logic ir,
                        input logic ie, input logic bk, input logic wd,
                        input logic sw, input logic sd, input logic [5:0] exp,
                        input string tag);
        @(negedge clk);
        rst_n = rst; wait_exec = we; irq_req = ir; irq_en = ie;
        brk_req = bk; wdog_dis = wd; stat_wr = sw; stat_wdata = sd;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    // monitor: compare away from the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [5:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {cpu_clk_en, per_clk_en, wdog_en, imask_clr, stack_go, stat_rdata};
            n_tests++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: {cpu,per,wdog,mask,stack,flag} got %b expected %b", t, a, e);
            end
        end
    end

    initial begin
        //           rst we ir ie bk wd sw sd  cpu per wd mk st fl
        step(0, 0,0,0,0, 0, 0,0, 6'b111000, "R1 reset held");
        step(1, 0,0,0,0, 0, 0,0, 6'b111000, "R1 after release");
        step(1, 1,0,0,0, 0, 0,0, 6'b011100, "R2 entry mask pulse");
        step(1, 0,0,0,0, 0, 0,0, 6'b011000, "R2 R3 mask one cycle, asleep");
        step(1, 0,1,0,0, 0, 0,0, 6'b011000, "R4 request without enable");
        step(1, 0,0,1,0, 0, 0,0, 6'b011000, "R4 enable without request");
        step(1, 0,1,1,0, 0, 0,0, 6'b111010, "R5 irq wake stack pulse");
        step(1, 0,0,0,0, 0, 0,0, 6'b111000, "R5 stack one cycle");
        step(1, 1,0,0,0, 1, 0,0, 6'b010100, "R9 watchdog off on entry");
        step(1, 0,0,0,0, 1, 0,0, 6'b010000, "R9 watchdog off asleep");
        step(1, 0,1,1,1, 1, 0,0, 6'b110001, "R6 R7 break beats irq, flag set");
        step(1, 0,0,0,0, 0, 0,0, 6'b111001, "R7 flag sticky");
        step(1, 0,0,0,0, 0, 1,1, 6'b111001, "R8 write one keeps flag");
        step(1, 0,0,0,0, 0, 1,0, 6'b111000, "R8 write zero clears");
        step(1, 0,0,0,1, 0, 0,0, 6'b111000, "R7 break while running ignored");
        step(1, 1,0,0,0, 0, 0,0, 6'b011100, "R2 second entry");
        step(1, 0,0,0,1, 0, 0,0, 6'b111001, "R6 break in first sleep cycle");
        step(1, 1,0,0,0, 0, 0,0, 6'b011101, "R3 sleep with flag set");
        step(1, 0,0,0,0, 0, 0,0, 6'b011001, "R3 still asleep");
        step(0, 0,1,1,1, 0, 0,0, 6'b111000, "R10 reset during wait");
        step(1, 0,0,0,0, 0, 0,0, 6'b111000, "R10 run after reset");
        step(1, 0,0,0,0, 0, 0,0, 6'b111000, "R1 idle run");
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule